// File: doc/BRIEF.md
# Write-Back Cache Tag Controller

This block is the tag and control half of a set-associative cache that uses write-back and write-allocate. It takes one access at a time over a valid/ready port. Each access carries a byte address, a byte count and a load/store flag. The block looks the address up in its tag store and answers hit or miss. On a miss it picks a victim way from a pseudo-random sequence and allocates the new line in that way. If the victim held modified data, it first issues a full-line write to the next memory level. It then issues a line-aligned full-line read. Both downstream requests use their own valid/ready handshake.

The data array and the next memory level sit outside the block. The block also keeps running statistics: access and miss counts split into loads and stores, bytes read and bytes written, and the number of writebacks. The set count, the way count and the line size are parameters.

Top module: `wbc_ctrl`

## Requirements
- R1: After reset every entry is invalid and clean, and all seven counters read zero. `req_ready_o` is high, and neither `mem_valid_o` nor `rsp_valid_o` is asserted.
- R2: The set index is `(addr >> log2(LINE_B)) & (SETS-1)`. Each entry stores the whole line address `addr >> log2(LINE_B)`. An access hits when a valid entry of the indexed set holds that line address, whatever its dirty flag.
- R3: A hit issues no memory request. The cycle after acceptance shows `rsp_valid_o`=1 and `rsp_hit_o`=1.
- R4: On a miss the victim way is `lfsr % WAYS`. The LFSR is 16 bits, reset to 16'hACE1, and steps only on a miss, after the victim is taken, as `next = {cur[14:0], cur[15]^cur[13]^cur[12]^cur[10]}`.
- R5: The victim entry is overwritten with the new line address and marked valid. It is left clean for a load and marked dirty for a store.
- R6: If the victim was valid and dirty, the first memory request is a write (`mem_write_o`=1) of `LINE_B` bytes at the victim's stored line address shifted left by log2(LINE_B).
- R7: Every miss issues a read (`mem_write_o`=0) of `LINE_B` bytes at the request address with its offset bits cleared. The read comes after any writeback has been accepted. The cycle after the read is accepted shows `rsp_valid_o`=1 and `rsp_hit_o`=0.
- R8: A store marks the line dirty on a hit as well as on a miss.
- R9: The counters hold the number of loads, stores, load misses and store misses, the sum of byte counts for loads, the sum of byte counts for stores, and the number of accepted writebacks.
- R10: From the acceptance of a miss until its read is accepted, `req_ready_o` is low. A pending memory request keeps its address and direction until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request valid |
| req_ready_o | output | 1 | Block can take an access |
| req_addr_i | input | ADDR_W | Byte address of the access |
| req_bytes_i | input | BYTES_W | Byte count of the access |
| req_store_i | input | 1 | 1 = store, 0 = load |
| rsp_valid_o | output | 1 | Access complete (one cycle) |
| rsp_hit_o | output | 1 | Completed access was a hit |
| mem_valid_o | output | 1 | Downstream request valid |
| mem_ready_i | input | 1 | Downstream request accepted |
| mem_addr_o | output | ADDR_W | Downstream line address |
| mem_write_o | output | 1 | 1 = writeback, 0 = fill |
| mem_bytes_o | output | BYTES_W | Downstream size, always LINE_B |
| cnt_rd_acc_o | output | CNT_W | Load count |
| cnt_wr_acc_o | output | CNT_W | Store count |
| cnt_rd_miss_o | output | CNT_W | Load miss count |
| cnt_wr_miss_o | output | CNT_W | Store miss count |
| cnt_rd_bytes_o | output | CNT_W | Bytes loaded |
| cnt_wr_bytes_o | output | CNT_W | Bytes stored |
| cnt_wb_o | output | CNT_W | Writeback count |

## Verification
The bench builds the block with 4 sets, 3 ways and 16-byte lines. Three ways is not a power of two, so the victim choice needs a true modulo of the LFSR value rather than a bit slice. Random addresses are drawn from only 32 lines against 12 entries. This keeps hits, clean evictions and dirty writebacks all frequent. Directed runs thrash a single set to force dirty victims and check both the writeback address and the fill alignment.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_FILL = 2'd2
  } wbc_state_e;

  localparam logic [15:0] LFSR_SEED = 16'hACE1;
endpackage

// File: rtl/wbc_lfsr.sv
module wbc_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        step_i,
  output logic [15:0] q_o
);
  logic [15:0] q_q;

  // taps 16,14,13,11: maximal length
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= SEED;
    else if (step_i) q_q <= {q_q[14:0], q_q[15] ^ q_q[13] ^ q_q[12] ^ q_q[10]};
  end

  assign q_o = q_q;
endmodule

// File: rtl/wbc_tag_store.sv
module wbc_tag_store #(
  parameter int SETS   = 64,
  parameter int WAYS   = 4,
  parameter int IDX_W  = 6,
  parameter int WAY_W  = 2,
  parameter int LINE_W = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [LINE_W-1:0] line_i,
  output logic              hit_o,
  output logic [WAY_W-1:0]  hit_way_o,
  input  logic [WAY_W-1:0]  vic_way_i,
  output logic              vic_valid_o,
  output logic              vic_dirty_o,
  output logic [LINE_W-1:0] vic_line_o,
  input  logic              alloc_i,
  input  logic              alloc_dirty_i,
  input  logic              mark_i
);
  logic [WAYS-1:0]   valid_q [SETS];
  logic [WAYS-1:0]   dirty_q [SETS];
  logic [LINE_W-1:0] line_q  [SETS][WAYS];
  logic [WAYS-1:0]   match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    // dirty flag plays no part in the match
    assign match[w] = valid_q[idx_i][w] && (line_q[idx_i][w] == line_i);
  end

  always_comb begin
    hit_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (match[w]) hit_way_o = WAY_W'(w);
  end

  assign hit_o       = |match;
  assign vic_valid_o = valid_q[idx_i][vic_way_i];
  assign vic_dirty_o = dirty_q[idx_i][vic_way_i];
  assign vic_line_o  = line_q[idx_i][vic_way_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else if (alloc_i) begin
      valid_q[idx_i][vic_way_i] <= 1'b1;
      dirty_q[idx_i][vic_way_i] <= alloc_dirty_i;
    end else if (mark_i) begin
      dirty_q[idx_i][hit_way_o] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (alloc_i) line_q[idx_i][vic_way_i] <= line_i;
  end
endmodule

// File: rtl/wbc_stats.sv
module wbc_stats #(
  parameter int CNT_W   = 32,
  parameter int BYTES_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_i,
  input  logic               store_i,
  input  logic               miss_i,
  input  logic [BYTES_W-1:0] bytes_i,
  input  logic               wb_i,
  output logic [CNT_W-1:0]   rd_acc_o,
  output logic [CNT_W-1:0]   wr_acc_o,
  output logic [CNT_W-1:0]   rd_miss_o,
  output logic [CNT_W-1:0]   wr_miss_o,
  output logic [CNT_W-1:0]   rd_bytes_o,
  output logic [CNT_W-1:0]   wr_bytes_o,
  output logic [CNT_W-1:0]   wb_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_acc_o   <= '0;
      wr_acc_o   <= '0;
      rd_miss_o  <= '0;
      wr_miss_o  <= '0;
      rd_bytes_o <= '0;
      wr_bytes_o <= '0;
      wb_o       <= '0;
    end else begin
      if (acc_i && !store_i) begin
        rd_acc_o   <= rd_acc_o + 1'b1;
        rd_bytes_o <= rd_bytes_o + CNT_W'(bytes_i);
        if (miss_i) rd_miss_o <= rd_miss_o + 1'b1;
      end
      if (acc_i && store_i) begin
        wr_acc_o   <= wr_acc_o + 1'b1;
        wr_bytes_o <= wr_bytes_o + CNT_W'(bytes_i);
        if (miss_i) wr_miss_o <= wr_miss_o + 1'b1;
      end
      if (wb_i) wb_o <= wb_o + 1'b1;
    end
  end
endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
  import wbc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SETS    = 64,
  parameter int WAYS    = 4,
  parameter int LINE_B  = 64,
  parameter int BYTES_W = 8,
  parameter int CNT_W   = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [BYTES_W-1:0] req_bytes_i,
  input  logic               req_store_i,
  output logic               rsp_valid_o,
  output logic               rsp_hit_o,
  output logic               mem_valid_o,
  input  logic               mem_ready_i,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic               mem_write_o,
  output logic [BYTES_W-1:0] mem_bytes_o,
  output logic [CNT_W-1:0]   cnt_rd_acc_o,
  output logic [CNT_W-1:0]   cnt_wr_acc_o,
  output logic [CNT_W-1:0]   cnt_rd_miss_o,
  output logic [CNT_W-1:0]   cnt_wr_miss_o,
  output logic [CNT_W-1:0]   cnt_rd_bytes_o,
  output logic [CNT_W-1:0]   cnt_wr_bytes_o,
  output logic [CNT_W-1:0]   cnt_wb_o
);
  localparam int OFF_W  = $clog2(LINE_B);
  localparam int IDX_W  = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int LINE_W = ADDR_W - OFF_W;

  wbc_state_e        state_q, state_d;
  logic [LINE_W-1:0] wb_line_q, fill_line_q;
  logic              rsp_valid_q, rsp_hit_q;

  logic [IDX_W-1:0]  idx;
  logic [LINE_W-1:0] line;
  logic              hit, accept, miss_acc, hit_acc;
  logic [WAY_W-1:0]  hit_way, vic_way;
  logic              vic_valid, vic_dirty;
  logic [LINE_W-1:0] vic_line;
  logic [15:0]       lfsr_q;

  assign idx  = IDX_W'((req_addr_i >> OFF_W) & ADDR_W'(SETS - 1));
  assign line = req_addr_i[ADDR_W-1:OFF_W];

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign hit_acc     = accept && hit;
  assign miss_acc    = accept && !hit;
  assign vic_way     = WAY_W'(lfsr_q % 16'(WAYS));

  wbc_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(miss_acc),
    .q_o   (lfsr_q)
  );

  wbc_tag_store #(
    .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W), .LINE_W(LINE_W)
  ) u_tags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .idx_i        (idx),
    .line_i       (line),
    .hit_o        (hit),
    .hit_way_o    (hit_way),
    .vic_way_i    (vic_way),
    .vic_valid_o  (vic_valid),
    .vic_dirty_o  (vic_dirty),
    .vic_line_o   (vic_line),
    .alloc_i      (miss_acc),
    .alloc_dirty_i(req_store_i),
    .mark_i       (hit_acc && req_store_i)
  );

  wbc_stats #(.CNT_W(CNT_W), .BYTES_W(BYTES_W)) u_stats (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (accept),
    .store_i   (req_store_i),
    .miss_i    (!hit),
    .bytes_i   (req_bytes_i),
    .wb_i      (state_q == ST_WB && mem_ready_i),
    .rd_acc_o  (cnt_rd_acc_o),
    .wr_acc_o  (cnt_wr_acc_o),
    .rd_miss_o (cnt_rd_miss_o),
    .wr_miss_o (cnt_wr_miss_o),
    .rd_bytes_o(cnt_rd_bytes_o),
    .wr_bytes_o(cnt_wr_bytes_o),
    .wb_o      (cnt_wb_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (miss_acc) state_d = (vic_valid && vic_dirty) ? ST_WB : ST_FILL;
      ST_WB:   if (mem_ready_i) state_d = ST_FILL;
      ST_FILL: if (mem_ready_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      wb_line_q   <= '0;
      fill_line_q <= '0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= hit_acc || (state_q == ST_FILL && mem_ready_i);
      rsp_hit_q   <= hit_acc;
      if (miss_acc) begin
        wb_line_q   <= vic_line;
        fill_line_q <= line;
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_hit_o   = rsp_hit_q;
  assign mem_valid_o = (state_q != ST_IDLE);
  assign mem_write_o = (state_q == ST_WB);
  assign mem_addr_o  = {(state_q == ST_WB) ? wb_line_q : fill_line_q, {OFF_W{1'b0}}};
  assign mem_bytes_o = BYTES_W'(LINE_B);
endmodule

// File: rtl/wbc_ctrl_chk.sv
module wbc_ctrl_chk #(
  parameter int ADDR_W  = 32,
  parameter int LINE_B  = 64,
  parameter int BYTES_W = 8,
  parameter int CNT_W   = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic [ADDR_W-1:0]  req_addr_i,
  input logic [BYTES_W-1:0] req_bytes_i,
  input logic               req_store_i,
  input logic               rsp_valid_o,
  input logic               rsp_hit_o,
  input logic               mem_valid_o,
  input logic               mem_ready_i,
  input logic [ADDR_W-1:0]  mem_addr_o,
  input logic               mem_write_o,
  input logic [BYTES_W-1:0] mem_bytes_o,
  input logic [CNT_W-1:0]   cnt_rd_acc_o,
  input logic [CNT_W-1:0]   cnt_wr_acc_o,
  input logic [CNT_W-1:0]   cnt_rd_miss_o,
  input logic [CNT_W-1:0]   cnt_wr_miss_o,
  input logic [CNT_W-1:0]   cnt_rd_bytes_o,
  input logic [CNT_W-1:0]   cnt_wr_bytes_o,
  input logic [CNT_W-1:0]   cnt_wb_o
);
  localparam int OFF_W = $clog2(LINE_B);

  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_write_o)); // R10
  AST_BUSY_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> !req_ready_o); // R10
  AST_LINE_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> mem_bytes_o == BYTES_W'(LINE_B)); // R7
  AST_FILL_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_write_o |-> mem_addr_o[OFF_W-1:0] == '0); // R7
  AST_WB_THEN_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && mem_ready_i && mem_write_o |=> mem_valid_o && !mem_write_o); // R6
  AST_FILL_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && mem_ready_i && !mem_write_o |=> rsp_valid_o && !rsp_hit_o); // R7
  AST_RD_MISS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_rd_miss_o <= cnt_rd_acc_o); // R9
  AST_WR_MISS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_miss_o <= cnt_wr_acc_o); // R9
  AST_WB_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_valid_o && mem_ready_i && mem_write_o) |=> $stable(cnt_wb_o)); // R9
endmodule

bind wbc_ctrl wbc_ctrl_chk #(
  .ADDR_W(ADDR_W), .LINE_B(LINE_B), .BYTES_W(BYTES_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/wbc_ctrl_tb_top.sv
module wbc_ctrl_tb_top;
  localparam int ADDR_W = 32, SETS = 4, WAYS = 3, LINE_B = 16, BYTES_W = 8, CNT_W = 32;
  localparam int OFF_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_store = 1'b0, mem_ready = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [BYTES_W-1:0] req_bytes = '0;
  logic req_ready, rsp_valid, rsp_hit, mem_valid, mem_write;
  logic [ADDR_W-1:0] mem_addr;
  logic [BYTES_W-1:0] mem_bytes;
  logic [CNT_W-1:0] c_ra, c_wa, c_rm, c_wm, c_rb, c_wb_b, c_wbk;

  always #5 clk = ~clk;

  wbc_ctrl #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .LINE_B(LINE_B),
             .BYTES_W(BYTES_W), .CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_bytes_i(req_bytes), .req_store_i(req_store),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .mem_valid_o(mem_valid),
    .mem_ready_i(mem_ready), .mem_addr_o(mem_addr), .mem_write_o(mem_write),
    .mem_bytes_o(mem_bytes), .cnt_rd_acc_o(c_ra), .cnt_wr_acc_o(c_wa),
    .cnt_rd_miss_o(c_rm), .cnt_wr_miss_o(c_wm), .cnt_rd_bytes_o(c_rb),
    .cnt_wr_bytes_o(c_wb_b), .cnt_wb_o(c_wbk));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // model state
  bit          m_valid [SETS][WAYS];
  bit          m_dirty [SETS][WAYS];
  logic [27:0] m_line  [SETS][WAYS];
  logic [15:0] m_lfsr;
  longint      e_ra, e_wa, e_rm, e_wm, e_rb, e_wb_b, e_wbk;

  function automatic logic [15:0] lfsr_next(logic [15:0] c);
    return {c[14:0], c[15] ^ c[13] ^ c[12] ^ c[10]};
  endfunction

  function automatic int set_of(logic [ADDR_W-1:0] a);
    return int'((a >> OFF_W) & (SETS - 1));
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_cnt(string req);
    chk(c_ra == e_ra, req, "rd_acc", c_ra, e_ra);
    chk(c_wa == e_wa, req, "wr_acc", c_wa, e_wa);
    chk(c_rm == e_rm, req, "rd_miss", c_rm, e_rm);
    chk(c_wm == e_wm, req, "wr_miss", c_wm, e_wm);
    chk(c_rb == e_rb, req, "rd_bytes", c_rb, e_rb);
    chk(c_wb_b == e_wb_b, req, "wr_bytes", c_wb_b, e_wb_b);
    chk(c_wbk == e_wbk, req, "writebacks", c_wbk, e_wbk);
  endtask

  task automatic mem_step(bit exp_wr, logic [ADDR_W-1:0] exp_addr);
    chk(mem_valid == 1'b1, exp_wr ? "R6" : "R7", "mem_valid", mem_valid, 1);
    chk(mem_write == exp_wr, exp_wr ? "R6" : "R7", "mem_write", mem_write, exp_wr);
    chk(mem_addr == exp_addr, exp_wr ? "R6" : "R7", "mem_addr", mem_addr, exp_addr);
    chk(mem_bytes == BYTES_W'(LINE_B), "R7", "mem_bytes", mem_bytes, LINE_B);
    chk(req_ready == 1'b0, "R10", "req_ready while busy", req_ready, 0);
    repeat ($urandom % 3) begin
      @(negedge clk);
      chk(mem_valid && mem_write == exp_wr && mem_addr == exp_addr, "R10",
          "mem request held", mem_addr, exp_addr);
    end
    mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
  endtask

  task automatic access(logic [ADDR_W-1:0] a, logic [BYTES_W-1:0] b, bit st);
    int s, hw, vw;
    logic [27:0] ln;
    bit hit, wb;
    logic [ADDR_W-1:0] wb_addr;
    s = set_of(a);
    ln = a[ADDR_W-1:OFF_W];
    hit = 1'b0; hw = 0; wb = 1'b0; wb_addr = '0;
    for (int w = 0; w < WAYS; w++)
      if (!hit && m_valid[s][w] && m_line[s][w] == ln) begin hit = 1'b1; hw = w; end
    if (st) begin e_wa++; e_wb_b += b; end else begin e_ra++; e_rb += b; end
    if (hit) begin
      if (st) m_dirty[s][hw] = 1'b1;
    end else begin
      if (st) e_wm++; else e_rm++;
      vw = int'(m_lfsr % WAYS);
      m_lfsr = lfsr_next(m_lfsr);
      wb = m_valid[s][vw] && m_dirty[s][vw];
      wb_addr = {m_line[s][vw], 4'h0};
      if (wb) e_wbk++;
      m_valid[s][vw] = 1'b1;
      m_dirty[s][vw] = st;
      m_line[s][vw]  = ln;
    end
    chk(req_ready == 1'b1, "R10", "req_ready idle", req_ready, 1);
    req_valid = 1'b1; req_addr = a; req_bytes = b; req_store = st;
    @(negedge clk);
    req_valid = 1'b0;
    if (hit) begin
      chk(rsp_valid && rsp_hit, "R3", "hit response", {rsp_valid, rsp_hit}, 3);
      chk(mem_valid == 1'b0, "R3", "no mem on hit", mem_valid, 0);
    end else begin
      chk(rsp_valid == 1'b0, "R7", "early response", rsp_valid, 0);
      if (wb) mem_step(1'b1, wb_addr);
      mem_step(1'b0, {ln, 4'h0});
      chk(rsp_valid && !rsp_hit, "R7", "miss response", {rsp_valid, rsp_hit}, 2);
      chk(mem_valid == 1'b0, "R7", "mem idle after fill", mem_valid, 0);
    end
    chk_cnt(st ? "R8/R9" : "R9");
  endtask

  initial begin
    void'($urandom(32'd4242));
    m_lfsr = 16'hACE1;
    e_ra = 0; e_wa = 0; e_rm = 0; e_wm = 0; e_rb = 0; e_wb_b = 0; e_wbk = 0;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_valid[s][w] = 1'b0; m_dirty[s][w] = 1'b0; m_line[s][w] = '0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
    chk(mem_valid == 1'b0, "R1", "mem_valid", mem_valid, 0);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);
    chk_cnt("R1");
    // R2 first access misses on a clean cache, victim clean (no writeback)
    access(32'h0000_0008, 8'd4, 1'b1);
    // R2 dirty flag ignored in compare: load of same line hits
    access(32'h0000_000C, 8'd2, 1'b0);
    // R8 store hit on a clean line, later evicted with writeback
    access(32'h0000_0044, 8'd1, 1'b0);
    access(32'h0000_0040, 8'd4, 1'b1);
    // R4 R5 R6 thrash set 0 to force dirty victims; R7 offset cleared
    for (int i = 0; i < 12; i++)
      access(ADDR_W'(i * 64 + 'h4B), 8'd8, i[0]);
    // other sets untouched by set 0 traffic
    access(32'h0000_0015, 8'd3, 1'b0);
    access(32'h0000_0015, 8'd3, 1'b1);
    // random mix over 32 lines
    for (int i = 0; i < 400; i++)
      access(ADDR_W'($urandom % 512), BYTES_W'(1 << ($urandom % 4)), 1'($urandom % 2));
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule